// File: doc/BRIEF.md
# Window Discriminator Hit Qualifier

This block sits behind a pair of threshold comparators in a photon-counting pixel. It turns their outputs into clean count strobes. A signal pulse is counted only if it passes the lower threshold and stays below the upper one for the whole pulse. The upper comparator acts as a veto on the event that is pending. A pulse that overshoots the energy window is therefore dropped and not counted.

Both comparator levels enter through a synchroniser chain on the system clock. The synchronised lower level is edge-detected. The event is judged when the lower level falls, and an accepted event produces a strobe exactly one clock wide that can drive a counter increment. An enable input gates the block: while it is low, nothing is counted and any event in progress is forgotten.

Top module: `win_hit_qual`

## Requirements
- R1: While `rst_n` is low and on the first cycles after its release, `hit_stb` is 0, and no event or veto is pending.
- R2: A `lo_cmp` pulse with `hi_cmp` held low and `en` high gives exactly one strobe. If the clock edge that first samples `lo_cmp` low is edge k, then `hit_stb` is 1 in the cycle that follows edge k+2.
- R3: `hit_stb` is never high for two cycles in a row, including for a one-cycle `lo_cmp` pulse and for pulses separated by a single low cycle.
- R4: If `hi_cmp` is sampled high at any edge between the edge that samples the `lo_cmp` rise and the edge that samples its fall (both included), the pulse gives no strobe.
- R5: A `hi_cmp` pulse while `lo_cmp` is idle produces no strobe. It blocks the next `lo_cmp` pulse. A later pulse that has no upper crossing is counted again.
- R6: While `en` is low, `hit_stb` stays 0.
- R7: If `en` goes low while a `lo_cmp` pulse is in progress, that pulse is discarded. This holds even if `en` returns high before `lo_cmp` falls.
- R8: A `lo_cmp` pulse whose rise was sampled with `en` low gives no strobe, even if `en` is high when it falls.
- R9: A `hi_cmp` pulse only one clock long, sampled within a `lo_cmp` pulse, is enough to veto that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Counting enable; low discards pending events |
| lo_cmp | input | 1 | Lower-threshold comparator level |
| hi_cmp | input | 1 | Upper-threshold comparator level |
| hit_stb | output | 1 | One-cycle strobe for each qualified hit |

## Verification
The assertions treat `en` as a synchronous level that is stable around the clock edge. They treat the comparator inputs as levels that can change in any cycle but are seen only through the synchroniser. Both comparator levels and the enable are driven only at the falling clock edge, so every value is sampled cleanly. The vetoes are placed at the edges of the window on purpose: on the rise cycle, on the fall cycle, as a single cycle, and while idle. These placements exercise the rules the assertions rely on.

// File: rtl/whq_pkg.sv
package whq_pkg;

  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned CMP_W      = 2;
  localparam int unsigned LO_IDX     = 0;
  localparam int unsigned HI_IDX     = 1;

  // Pending-event flag: starts on an enabled rise, ends on fall or disable.
  function automatic logic next_armed(input logic en, input logic armed,
                                      input logic rise, input logic fall);
    if (!en)       return 1'b0;
    else if (fall) return 1'b0;
    else if (rise) return 1'b1;
    else           return armed;
  endfunction

  // Veto flag: set by any sampled upper crossing, consumed by the lower fall.
  function automatic logic next_veto(input logic en, input logic veto,
                                     input logic hi, input logic fall);
    if (!en || fall) return 1'b0;
    else             return veto | hi;
  endfunction

  function automatic logic qualifies(input logic en, input logic armed,
                                     input logic veto, input logic hi,
                                     input logic fall);
    return en & fall & armed & ~veto & ~hi;
  endfunction

endpackage

// File: rtl/whq_sync.sv
module whq_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/whq_edge.sv
module whq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;

endmodule

// File: rtl/whq_qualify.sv
module whq_qualify
  import whq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lo_rise,
  input  logic lo_fall,
  input  logic hi_lvl,
  output logic armed,
  output logic veto,
  output logic hit,
  output logic strobe
);

  assign hit = qualifies(en, armed, veto, hi_lvl, lo_fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      veto   <= 1'b0;
      strobe <= 1'b0;
    end else begin
      armed  <= next_armed(en, armed, lo_rise, lo_fall);
      veto   <= next_veto(en, veto, hi_lvl, lo_fall);
      strobe <= hit;
    end
  end

endmodule

// File: rtl/win_hit_qual.sv
module win_hit_qual
  import whq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lo_cmp,
  input  logic hi_cmp,
  output logic hit_stb
);

  logic [CMP_W-1:0] cmp_raw;
  logic [CMP_W-1:0] cmp_sync;
  logic lo_s, hi_s;
  logic lo_rise, lo_fall;
  logic ev_armed, ev_veto, ev_hit;

  assign cmp_raw[LO_IDX] = lo_cmp;
  assign cmp_raw[HI_IDX] = hi_cmp;

  whq_sync #(.W(CMP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmp_raw), .q(cmp_sync)
  );

  assign lo_s = cmp_sync[LO_IDX];
  assign hi_s = cmp_sync[HI_IDX];

  whq_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lo_s), .rise(lo_rise), .fall(lo_fall)
  );

  whq_qualify u_qual (
    .clk(clk), .rst_n(rst_n), .en(en),
    .lo_rise(lo_rise), .lo_fall(lo_fall), .hi_lvl(hi_s),
    .armed(ev_armed), .veto(ev_veto), .hit(ev_hit), .strobe(hit_stb)
  );

endmodule

// File: rtl/whq_checker.sv
module whq_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic lo_rise,
  input logic lo_fall,
  input logic hi_s,
  input logic armed,
  input logic veto,
  input logic hit_stb
);

  p_one_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stb |=> !hit_stb);

  p_strobe_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stb |-> $past(lo_fall));

  p_fall_hi_vetoes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stb |-> !$past(hi_s));

  p_veto_flag_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stb |-> !$past(veto));

  p_disabled_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !hit_stb);

  p_disable_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!armed && !veto));

  p_needs_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stb |-> $past(armed));

  p_hi_sets_veto_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hi_s && !lo_fall) |=> veto);

  p_reset_idle_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!hit_stb && !armed && !veto));

endmodule

bind win_hit_qual whq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en(en),
  .lo_rise(lo_rise), .lo_fall(lo_fall), .hi_s(hi_s),
  .armed(ev_armed), .veto(ev_veto), .hit_stb(hit_stb)
);

// File: tb/tb_win_hit_qual.sv
`timescale 1ns/1ps
module tb_win_hit_qual;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, lo_cmp = 1'b0, hi_cmp = 1'b0;
  logic hit_stb;

  always #10 clk = ~clk;

  win_hit_qual dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .lo_cmp(lo_cmp), .hi_cmp(hi_cmp), .hit_stb(hit_stb)
  );

  int errors = 0;
  int checks = 0;
  int nstb = 0;
  int stb_at = -1;
  int step_no = 0;
  bit prev_stb = 0;
  bit done = 0;

  // Behavioural reference: recent samples of each input, newest first.
  bit lo_h[$];
  bit hi_h[$];
  bit pending, overshoot, expect_stb;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: hit_stb=%0b expected %0b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    lo_h = '{0, 0, 0, 0};
    hi_h = '{0, 0, 0, 0};
    pending = 0; overshoot = 0; expect_stb = 0;
  endtask

  // Expected strobe after one clock edge, from the requirement rules.
  task automatic model_edge(input bit l, input bit h, input bit e);
    bit seen_lo, was_lo, seen_hi, went_up, went_down;
    seen_lo = lo_h[1]; was_lo = lo_h[2]; seen_hi = hi_h[1];
    went_up = seen_lo && !was_lo;
    went_down = !seen_lo && was_lo;
    expect_stb = e && went_down && pending && !overshoot && !seen_hi;
    if (!e) begin
      pending = 0; overshoot = 0;
    end else if (went_down) begin
      pending = 0; overshoot = 0;
    end else begin
      if (went_up) pending = 1;
      if (seen_hi) overshoot = 1;
    end
    lo_h.push_front(l); void'(lo_h.pop_back());
    hi_h.push_front(h); void'(hi_h.pop_back());
  endtask

  task automatic step(input bit l, input bit h, input bit e, input string req);
    lo_cmp = l; hi_cmp = h; en = e;
    @(posedge clk);
    model_edge(l, h, e);
    @(negedge clk);
    check(req, hit_stb, expect_stb);
    if (hit_stb) begin
      nstb++;
      if (stb_at < 0) stb_at = step_no;
    end
    if (hit_stb && prev_stb) check("R3 consecutive", 1'b1, 1'b0);
    prev_stb = hit_stb;
    step_no++;
  endtask

  task automatic pulse(input int lo_len, input int hi_off, input int hi_len,
                       input bit e, input string req);
    nstb = 0; stb_at = -1; step_no = 0;
    for (int i = 0; i < lo_len + 6; i++) begin
      step(i < lo_len, (hi_off >= 0) && (i >= hi_off) && (i < hi_off + hi_len), e, req);
    end
  endtask

  task automatic idle(input int n, input bit e);
    for (int i = 0; i < n; i++) step(0, 0, e, "idle");
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    repeat (3) @(negedge clk);
    check("R1 reset", hit_stb, 1'b0);
    rst_n = 1'b1;
    en = 1'b1;
    idle(3, 1);
    check("R1 after release", hit_stb, 1'b0);

    // R2: clean pulse, latency and count
    pulse(5, -1, 0, 1, "R2 clean");
    check_int("R2 count", nstb, 1);
    check_int("R2 latency", stb_at, 7);

    // R3: one-cycle pulse, then back-to-back pulses
    pulse(1, -1, 0, 1, "R3 short");
    check_int("R3 short count", nstb, 1);
    nstb = 0;
    for (int i = 0; i < 3; i++) step(1, 0, 1, "R3 b2b");
    step(0, 0, 1, "R3 b2b");
    for (int i = 0; i < 3; i++) step(1, 0, 1, "R3 b2b");
    idle(6, 1);
    check_int("R3 b2b count", nstb, 2);

    // R4: overshoot mid pulse, on rise cycle, on fall cycle
    pulse(6, 2, 2, 1, "R4 mid");
    check_int("R4 mid count", nstb, 0);
    pulse(4, 0, 1, 1, "R4 rise");
    check_int("R4 rise count", nstb, 0);
    pulse(4, 4, 1, 1, "R4 fall");
    check_int("R4 fall count", nstb, 0);
    pulse(3, -1, 0, 1, "R4 recover");
    check_int("R4 recover count", nstb, 1);

    // R5: upper crossing while idle blocks next pulse only
    for (int i = 0; i < 2; i++) step(0, 1, 1, "R5 idle hi");
    idle(4, 1);
    check_int("R5 idle no strobe", nstb, 1);
    pulse(3, -1, 0, 1, "R5 blocked");
    check_int("R5 blocked count", nstb, 0);
    pulse(3, -1, 0, 1, "R5 next");
    check_int("R5 next count", nstb, 1);

    // R6: disabled
    pulse(4, -1, 0, 0, "R6 disabled");
    check_int("R6 count", nstb, 0);
    idle(2, 1);

    // R7: enable drops mid pulse and returns
    nstb = 0;
    for (int i = 0; i < 4; i++) step(1, 0, 1, "R7 drop");
    step(1, 0, 0, "R7 drop");
    for (int i = 0; i < 2; i++) step(1, 0, 1, "R7 drop");
    idle(6, 1);
    check_int("R7 count", nstb, 0);

    // R8: rise seen while disabled
    nstb = 0;
    for (int i = 0; i < 4; i++) step(1, 0, 0, "R8 late en");
    for (int i = 0; i < 3; i++) step(1, 0, 1, "R8 late en");
    idle(6, 1);
    check_int("R8 count", nstb, 0);

    // R9: single-cycle upper pulse inside a long pulse
    pulse(8, 3, 1, 1, "R9 one cycle hi");
    check_int("R9 count", nstb, 0);
    pulse(2, -1, 0, 1, "R9 recover");
    check_int("R9 recover count", nstb, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule